// File: doc/BRIEF.md
# Single-Address Indexed Register Port

This block puts a bank of internal registers behind a single host-visible location. The host reaches all of them through that location, and each access lands either on an index or on the register that index points at. An internal one-bit phase flag decides which. A write in the index phase latches a register number. The following write stores a value in that register. A read in that position returns the register's contents instead. None of the internal registers has an address of its own in the host's map.

The host side is a simple synchronous bus. It has a select strobe, a write enable, write data and a registered read data output. Every register in the bank is also driven out in parallel on a flat bus for the rest of the device. The bank defaults to 16 registers of 8 bits. Both counts are parameters.

Top module: `idx_reg_port`

## Requirements
- R1: After reset every internal register reads zero on `regs_o`, `rdata_o` is zero, and the phase flag is in the index phase.
- R2: A write (`sel_i`=1, `we_i`=1) in the index phase stores `wdata_i` as the selected index, moves the phase to data, and leaves every internal register unchanged.
- R3: A write in the data phase whose index is below the register count stores `wdata_i` into that register. The new value shows on `regs_o` slice `[idx*DATA_W +: DATA_W]` after that clock edge. All other registers are left alone.
- R4: A read (`sel_i`=1, `we_i`=0) in the data phase loads the selected register into `rdata_o` at that clock edge and returns the phase to the index phase.
- R5: The phase flag toggles on every host write. Consecutive writes therefore alternate index, data, index, data.
- R6: An index at or above the register count makes a data-phase write change no register, and makes a data-phase read return zero. The phase still advances as in R4 and R5.
- R7: A read in the index phase loads zero into `rdata_o` and leaves the phase in the index phase.
- R8: While `sel_i` is low, neither the registers, `rdata_o`, nor the phase change, whatever `we_i` and `wdata_i` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Access strobe for the single port location, one access per cycle it is high |
| we_i | input | 1 | 1 = write access, 0 = read access |
| wdata_i | input | DATA_W | Host write data (index or register value) |
| rdata_o | output | DATA_W | Registered read data, updated on the edge of a read access |
| regs_o | output | NUM_REGS*DATA_W | Parallel view of the bank, register k in bits [k*DATA_W +: DATA_W] |

## Verification
The properties assume that `sel_i`, `we_i` and `wdata_i` are stable and known at each rising edge. They also assume that one host access occupies exactly one cycle in which `sel_i` is high. The bench drives every input on the falling edge and holds it through the next rising edge. It covers each access as a single-cycle strobe and also as back-to-back strobes. It sends out-of-range indices and index-phase reads on purpose, so that the properties for those paths are exercised and not left vacuous.

// File: rtl/idx_port_pkg.sv
package idx_port_pkg;
  typedef enum logic {
    PH_INDEX = 1'b0,
    PH_DATA  = 1'b1
  } phase_e;
endpackage

// File: rtl/idx_port_ctrl.sv
module idx_port_ctrl
  import idx_port_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int DATA_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output phase_e            phase_o,
  output logic [DATA_W-1:0] index_o,
  output logic              in_range_o,
  output logic              bank_we_o,
  output logic              rd_fire_o
);
  phase_e            phase_q, phase_d;
  logic [DATA_W-1:0] index_q;
  logic              wr_acc, rd_acc;

  assign wr_acc     = sel_i & we_i;
  assign rd_acc     = sel_i & ~we_i;
  assign in_range_o = ({1'b0, index_q} < (DATA_W+1)'(NUM_REGS));
  assign bank_we_o  = wr_acc && (phase_q == PH_DATA) && in_range_o;
  assign rd_fire_o  = rd_acc;

  always_comb begin
    phase_d = phase_q;
    if (wr_acc)      phase_d = (phase_q == PH_INDEX) ? PH_DATA : PH_INDEX;
    else if (rd_acc) phase_d = PH_INDEX;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_INDEX;
      index_q <= '0;
    end else begin
      phase_q <= phase_d;
      if (wr_acc && (phase_q == PH_INDEX)) index_q <= wdata_i;
    end
  end

  assign phase_o = phase_q;
  assign index_o = index_q;
endmodule

// File: rtl/idx_port_bank.sv
module idx_port_bank #(
  parameter int NUM_REGS = 16,
  parameter int DATA_W   = 8,
  localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [IDX_W-1:0]           idx_i,
  input  logic [DATA_W-1:0]          wdata_i,
  output logic [NUM_REGS*DATA_W-1:0] regs_o
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         q <= '0;
      else if (we_i && idx_i == IDX_W'(g)) q <= wdata_i;
    end
    assign regs_o[g*DATA_W +: DATA_W] = q;
  end
endmodule

// File: rtl/idx_port_rdmux.sv
module idx_port_rdmux
  import idx_port_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int DATA_W   = 8,
  localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       rd_fire_i,
  input  phase_e                     phase_i,
  input  logic                       in_range_i,
  input  logic [IDX_W-1:0]           idx_i,
  input  logic [NUM_REGS*DATA_W-1:0] regs_i,
  output logic [DATA_W-1:0]          rdata_o
);
  logic [DATA_W-1:0] pick, rd_d;

  always_comb begin
    pick = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (idx_i == IDX_W'(i)) pick = regs_i[i*DATA_W +: DATA_W];
  end

  // index-phase reads and out-of-range reads both return zero
  assign rd_d = (phase_i == PH_DATA && in_range_i) ? pick : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        rdata_o <= '0;
    else if (rd_fire_i) rdata_o <= rd_d;
  end
endmodule

// File: rtl/idx_reg_port.sv
module idx_reg_port
  import idx_port_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int DATA_W   = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       sel_i,
  input  logic                       we_i,
  input  logic [DATA_W-1:0]          wdata_i,
  output logic [DATA_W-1:0]          rdata_o,
  output logic [NUM_REGS*DATA_W-1:0] regs_o
);
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  phase_e            phase;
  logic [DATA_W-1:0] index;
  logic              in_range, bank_we, rd_fire;
  logic [IDX_W-1:0]  idx_s;

  assign idx_s = index[IDX_W-1:0];

  idx_port_ctrl #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) i_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_i      (sel_i),
    .we_i       (we_i),
    .wdata_i    (wdata_i),
    .phase_o    (phase),
    .index_o    (index),
    .in_range_o (in_range),
    .bank_we_o  (bank_we),
    .rd_fire_o  (rd_fire)
  );

  idx_port_bank #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) i_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (bank_we),
    .idx_i   (idx_s),
    .wdata_i (wdata_i),
    .regs_o  (regs_o)
  );

  idx_port_rdmux #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) i_rdmux (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_fire_i  (rd_fire),
    .phase_i    (phase),
    .in_range_i (in_range),
    .idx_i      (idx_s),
    .regs_i     (regs_o),
    .rdata_o    (rdata_o)
  );
endmodule

// File: rtl/idx_reg_port_chk.sv
module idx_reg_port_chk
  import idx_port_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int DATA_W   = 8
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       sel_i,
  input logic                       we_i,
  input logic [DATA_W-1:0]          wdata_i,
  input logic [DATA_W-1:0]          rdata_o,
  input logic [NUM_REGS*DATA_W-1:0] regs_o,
  input phase_e                     phase,
  input logic [DATA_W-1:0]          index
);
  logic              rng;
  logic [DATA_W-1:0] tgt;

  assign rng = ({1'b0, index} < (DATA_W+1)'(NUM_REGS));

  always_comb begin
    tgt = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if ({1'b0, index} == (DATA_W+1)'(i)) tgt = regs_o[i*DATA_W +: DATA_W];
  end

  assert_idx_write_keeps_bank_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i && we_i && phase == PH_INDEX |=> $stable(regs_o) && phase == PH_DATA);

  assert_data_write_lands_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i && we_i && phase == PH_DATA && rng |=> tgt == $past(wdata_i));

  assert_read_returns_index_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i && !we_i && phase == PH_DATA |=> phase == PH_INDEX);

  assert_write_toggles_phase_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i && we_i |=> phase != $past(phase));

  assert_oob_write_dropped_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i && we_i && phase == PH_DATA && !rng |=> $stable(regs_o));

  assert_oob_read_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i && !we_i && phase == PH_DATA && !rng |=> rdata_o == '0);

  assert_idx_read_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i && !we_i && phase == PH_INDEX |=> rdata_o == '0 && phase == PH_INDEX);

  assert_idle_holds_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_i |=> $stable(regs_o) && $stable(rdata_o) && $stable(phase));
endmodule

bind idx_reg_port idx_reg_port_chk #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .sel_i   (sel_i),
  .we_i    (we_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .regs_o  (regs_o),
  .phase   (phase),
  .index   (index)
);

// File: tb/test_idx_reg_port.sv
module test_idx_reg_port;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16;
  localparam int W = 8;

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic           sel_i = 1'b0;
  logic           we_i = 1'b0;
  logic [W-1:0]   wdata_i = '0;
  logic [W-1:0]   rdata_o;
  logic [N*W-1:0] regs_o;

  int tests = 0;
  int fails = 0;

  logic [W-1:0] m_regs [N];
  logic         m_phase = 1'b0;
  logic [W-1:0] m_idx = '0;
  logic [W-1:0] exp_q[$];
  string        tag_q[$];

  idx_reg_port #(.NUM_REGS(N), .DATA_W(W)) i_idx_reg_port (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel_i), .we_i(we_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .regs_o(regs_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // driver: one access per call, model updated, read expectations queued
  task automatic wr(logic [W-1:0] d);
    @(negedge clk_i);
    sel_i = 1'b1; we_i = 1'b1; wdata_i = d;
    if (!m_phase) m_idx = d;
    else if (m_idx < W'(N)) m_regs[m_idx[3:0]] = d;
    m_phase = ~m_phase;
  endtask

  task automatic rd(string req);
    @(negedge clk_i);
    sel_i = 1'b1; we_i = 1'b0; wdata_i = 8'hA5;
    exp_q.push_back((m_phase && m_idx < W'(N)) ? m_regs[m_idx[3:0]] : '0);
    tag_q.push_back(req);
    m_phase = 1'b0;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk_i);
      sel_i = 1'b0; we_i = k[0]; wdata_i = W'(k * 37 + 11);
    end
  endtask

  task automatic check_bank(string req);
    for (int k = 0; k < N; k++) check(req, regs_o[k*W +: W], m_regs[k]);
  endtask

  // monitor: pops an expectation after each read edge
  initial begin
    forever begin
      @(posedge clk_i);
      if (rst_ni && sel_i && !we_i) begin
        #1;
        if (exp_q.size() == 0) check("queue", 8'hFF, 8'h00);
        else check(tag_q.pop_front(), rdata_o, exp_q.pop_front());
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    tests++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [W-1:0] hold;
    for (int k = 0; k < N; k++) m_regs[k] = '0;
    #(CLK_PERIOD * 3);
    @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state
    check("R1 rdata", rdata_o, '0);
    check_bank("R1 bank");

    // R1/R2/R3: first write acts as index
    wr(8'd3); idle(1);
    check_bank("R2 index write leaves bank");
    wr(8'h5C); idle(1);
    check("R3 reg3", regs_o[3*W +: W], 8'h5C);
    check_bank("R3 others");

    // R4 read back, then phase back to index
    wr(8'd3); rd("R4 read reg3");
    wr(8'd7); wr(8'hE1); idle(1);
    check("R4 phase returned to index", regs_o[7*W +: W], 8'hE1);

    // R5 back-to-back writes over all registers
    for (int k = 0; k < N; k++) begin
      wr(W'(k)); wr(W'(8'h10 + k * 13));
    end
    idle(1);
    check_bank("R5 alternating writes");
    for (int k = N - 1; k >= 0; k--) begin
      wr(W'(k)); rd("R4 sweep read");
    end

    // R6 out-of-range index
    wr(8'd16); wr(8'hFF); idle(1);
    check_bank("R6 oob write dropped");
    wr(8'd200); rd("R6 oob read zero");
    wr(8'd0); wr(8'h42); idle(1);
    check("R6 phase advanced after oob", regs_o[0 +: W], 8'h42);

    // R7 read in index phase: zero, phase stays index
    rd("R7 idx-phase read");
    wr(8'd9); wr(8'h99); idle(1);
    check("R7 phase kept index", regs_o[9*W +: W], 8'h99);

    // R8 idle cycles with noise on we/wdata
    wr(8'd9); rd("R8 pre-idle read");
    idle(1);
    hold = rdata_o;
    idle(6);
    check("R8 rdata held", rdata_o, hold);
    check_bank("R8 bank held");
    wr(8'd2); idle(3); wr(8'h77); idle(1);
    check("R8 phase held across idle", regs_o[2*W +: W], 8'h77);

    idle(2);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule